// File: doc/BRIEF.md
# Event Code Action Decoder

The decoder turns each 8-bit event code taken from a timing link into a 16-bit action word. It keeps two lookup tables of 256 words each, and one of them is live at any time. A host write port can fill either table while the other one decodes. A select input chooses the live table, so a new set of mappings can be swapped in between two events, never during one.

The three top bits of the action word drive fixed control strobes: bit 13 requests a delayed interrupt, bit 14 latches the timestamp and bit 15 writes the event into the event FIFO. The low 13 bits leave the block as trigger strobes for hardware outputs. Bit 0 also starts a built-in pulse generator. The generator has a 32-bit delay, a 16-bit width and a polarity select, and it counts in event-clock cycles.

Top module: `evmap_decoder`

## Requirements
- R1: While rst_ni is low and after its release with no input activity, act_valid_o, act_o, trig_o and the three control strobes are 0, pulse_o equals pulse_pol_i, and table 0 is the live table.
- R2: A code with code_valid_i high at a rising edge gives act_valid_o = 1 and act_o = live table[code_i] from that edge for exactly one cycle. A cycle with code_valid_i low gives act_valid_o = 0.
- R3: A write with wr_en_i high stores wr_data_i at wr_addr_i of the table chosen by wr_bank_i (0 or 1) and touches neither the other table nor the outputs.
- R4: The live table is the value of bank_sel_i registered at the previous edge. A change of bank_sel_i at the same edge as a code has no effect on that code's word.
- R5: When a write and a lookup hit the same entry of the live table at the same edge, the lookup returns the content from before the write. The next lookup returns the new content.
- R6: Code 0x00 gives act_valid_o = 1 with an all-zero action word, whatever the table holds at address 0.
- R7: dly_irq_o, ts_latch_o and fifo_wr_o equal bits 13, 14 and 15 of act_o while act_valid_o is high, and are 0 otherwise.
- R8: trig_o equals bits 12..0 of act_o while act_valid_o is high, and is 0 otherwise.
- R9: If a code whose word has bit 0 set is sampled at edge E, with delay D and width W ≠ 0 at edge E+1, pulse_o holds the active level from edge E+1+D for exactly W cycles.
- R10: The idle level of pulse_o is pulse_pol_i and the active level is its inverse (pulse_pol_i = 0 gives an active-high pulse).
- R11: A width value of zero at the trigger edge gives no pulse. pulse_o stays at the idle level.
- R12: A trigger that arrives while a pulse is already delaying or active is ignored. The running pulse keeps its timing and no second pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Event clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_bank_i | input | 1 | Table chosen for the write |
| wr_addr_i | input | 8 | Entry written |
| wr_data_i | input | 16 | Word written |
| bank_sel_i | input | 1 | Requested live table |
| code_valid_i | input | 1 | Event code present |
| code_i | input | 8 | Received event code |
| pulse_delay_i | input | 32 | Pulse delay in cycles |
| pulse_width_i | input | 16 | Pulse width in cycles, 0 disables |
| pulse_pol_i | input | 1 | Pulse idle level |
| act_valid_o | output | 1 | Action word valid |
| act_o | output | 16 | Action word |
| trig_o | output | 13 | Hardware trigger strobes |
| dly_irq_o | output | 1 | Delayed interrupt request |
| ts_latch_o | output | 1 | Timestamp latch strobe |
| fifo_wr_o | output | 1 | Event FIFO write strobe |
| pulse_o | output | 1 | Programmable pulse |

## Verification
Both tables are filled with a computed pattern that differs between them. Every code is then looked up in each, so a swapped bank select or a wrong bit in a control or trigger strobe shows up in the sweep. Address 0 holds a nonzero word, so a design that forwarded it instead of forcing zero fails R6. Dedicated cycles change the select at the same edge as a code, and write an entry at the same edge as its lookup. A design that switched the live table early, or passed a write through to the read, returns the wrong word there. The pulse is measured by its first active cycle and its length over several delay, width and polarity settings, including zero delay, zero width and a retrigger during the delay phase. An off-by-one counter or a restart on retrigger changes those numbers.

// File: rtl/evmap_pkg.sv
package evmap_pkg;
  localparam int CODE_W   = 8;
  localparam int WORD_W   = 16;
  localparam int IRQ_BIT  = 13;
  localparam int TS_BIT   = 14;
  localparam int FIFO_BIT = 15;
  localparam int PULSE_BIT = 0;

  typedef enum logic [1:0] {PS_IDLE, PS_DELAY, PS_ACTIVE} pulse_state_e;
endpackage

// File: rtl/evmap_table.sv
module evmap_table #(
  parameter int CODE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [CODE_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [CODE_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << CODE_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read is combinational; the caller registers the result
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/evmap_pulse.sv
module evmap_pulse
  import evmap_pkg::*;
#(
  parameter int DLY_W = 32,
  parameter int WID_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [WID_W-1:0] width_i,
  input  logic             pol_i,
  output logic             pulse_o
);
  pulse_state_e     state_q;
  logic [DLY_W-1:0] dcnt_q;
  logic [WID_W-1:0] wcnt_q;
  logic [WID_W-1:0] wlat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE;
      dcnt_q  <= '0;
      wcnt_q  <= '0;
      wlat_q  <= '0;
    end else begin
      unique case (state_q)
        PS_IDLE: begin
          if (trig_i && (width_i != '0)) begin
            wlat_q <= width_i;
            if (delay_i == '0) begin
              state_q <= PS_ACTIVE;
              wcnt_q  <= width_i;
            end else begin
              state_q <= PS_DELAY;
              dcnt_q  <= delay_i;
            end
          end
        end
        PS_DELAY: begin
          if (dcnt_q == DLY_W'(1)) begin
            state_q <= PS_ACTIVE;
            wcnt_q  <= wlat_q;
          end else begin
            dcnt_q <= dcnt_q - DLY_W'(1);
          end
        end
        PS_ACTIVE: begin
          if (wcnt_q == WID_W'(1)) state_q <= PS_IDLE;
          else                     wcnt_q  <= wcnt_q - WID_W'(1);
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  assign pulse_o = (state_q == PS_ACTIVE) ^ pol_i;
endmodule

// File: rtl/evmap_decoder.sv
module evmap_decoder
  import evmap_pkg::*;
#(
  parameter int CODE_W = evmap_pkg::CODE_W,
  parameter int WORD_W = evmap_pkg::WORD_W,
  parameter int DLY_W  = 32,
  parameter int WID_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_bank_i,
  input  logic [CODE_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              bank_sel_i,
  input  logic              code_valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DLY_W-1:0]  pulse_delay_i,
  input  logic [WID_W-1:0]  pulse_width_i,
  input  logic              pulse_pol_i,
  output logic              act_valid_o,
  output logic [WORD_W-1:0] act_o,
  output logic [IRQ_BIT-1:0] trig_o,
  output logic              dly_irq_o,
  output logic              ts_latch_o,
  output logic              fifo_wr_o,
  output logic              pulse_o
);
  localparam int NUM_TABLES = 2;
  localparam int TRIG_W     = IRQ_BIT;

  logic [WORD_W-1:0] rd_word [NUM_TABLES];
  logic              live_q;
  logic [WORD_W-1:0] act_d;
  logic [WORD_W-1:0] act_q;
  logic              act_valid_q;

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tab
    evmap_table #(.CODE_W(CODE_W), .WORD_W(WORD_W)) table_i (
      .clk_i   (clk_i),
      .we_i    (wr_en_i && (wr_bank_i == 1'(t))),
      .waddr_i (wr_addr_i),
      .wdata_i (wr_data_i),
      .raddr_i (code_i),
      .rdata_o (rd_word[t])
    );
  end

  // null code never maps to an action
  assign act_d = (code_i == '0) ? '0 : rd_word[live_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q      <= 1'b0;
      act_valid_q <= 1'b0;
      act_q       <= '0;
    end else begin
      live_q      <= bank_sel_i;
      act_valid_q <= code_valid_i;
      act_q       <= code_valid_i ? act_d : '0;
    end
  end

  assign act_valid_o = act_valid_q;
  assign act_o       = act_q;
  assign trig_o      = act_valid_q ? act_q[TRIG_W-1:0] : '0;
  assign dly_irq_o   = act_valid_q & act_q[IRQ_BIT];
  assign ts_latch_o  = act_valid_q & act_q[TS_BIT];
  assign fifo_wr_o   = act_valid_q & act_q[FIFO_BIT];

  evmap_pulse #(.DLY_W(DLY_W), .WID_W(WID_W)) pulse_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (act_valid_q & act_q[PULSE_BIT]),
    .delay_i (pulse_delay_i),
    .width_i (pulse_width_i),
    .pol_i   (pulse_pol_i),
    .pulse_o (pulse_o)
  );
endmodule

// File: rtl/evmap_decoder_chk.sv
module evmap_decoder_chk #(
  parameter int CODE_W = 8,
  parameter int WORD_W = 16,
  parameter int TRIG_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              code_valid_i,
  input logic [CODE_W-1:0] code_i,
  input logic              act_valid_o,
  input logic [WORD_W-1:0] act_o,
  input logic [TRIG_W-1:0] trig_o,
  input logic              dly_irq_o,
  input logic              ts_latch_o,
  input logic              fifo_wr_o
);
  AST_CODE_TO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_i |=> act_valid_o); // R2

  AST_NO_CODE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_valid_i |=> !act_valid_o); // R2

  AST_NULL_CODE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_valid_i && (code_i == '0)) |=> (act_o == '0)); // R6

  AST_CTRL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_valid_o |-> (!dly_irq_o && !ts_latch_o && !fifo_wr_o)); // R7

  AST_TRIG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_valid_o |-> (trig_o == '0)); // R8
endmodule

bind evmap_decoder evmap_decoder_chk #(
  .CODE_W(CODE_W), .WORD_W(WORD_W), .TRIG_W(TRIG_W)
) chk_i (.*);

// File: tb/evmap_decoder_tb_top.sv
module evmap_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [7:0] PCODE = 8'h22;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_bank_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        bank_sel_i = 1'b0;
  logic        code_valid_i = 1'b0;
  logic [7:0]  code_i = '0;
  logic [31:0] pulse_delay_i = '0;
  logic [15:0] pulse_width_i = '0;
  logic        pulse_pol_i = 1'b0;
  logic        act_valid_o;
  logic [15:0] act_o;
  logic [12:0] trig_o;
  logic        dly_irq_o, ts_latch_o, fifo_wr_o, pulse_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  evmap_decoder dut_i (.*);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] fill(input logic b, input logic [7:0] c);
    return {c, ~c} ^ (b ? 16'h3C5A : 16'h0000);
  endfunction

  function automatic logic [33:0] bundle(input logic v, input logic [15:0] w, input logic pol);
    logic [15:0] g;
    g = v ? w : 16'h0;
    return {v, g[15], g[14], g[13], g[12:0], g, pol};
  endfunction

  task automatic check(input string req, input logic [63:0] actual, input logic [63:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  function automatic logic [33:0] outs();
    return {act_valid_o, fifo_wr_o, ts_latch_o, dly_irq_o, trig_o, act_o, pulse_o};
  endfunction

  task automatic sweep(input logic b);
    for (int i = 0; i <= 256; i++) begin
      @(negedge clk_i);
      if (i > 0) check("R2 R6 R7 R8 R11 sweep", 64'(outs()),
                       64'(bundle(1'b1, (i == 1) ? 16'h0 : fill(b, 8'(i-1)), pulse_pol_i)));
      code_valid_i = (i < 256);
      code_i       = 8'(i);
    end
    code_valid_i = 1'b0;
    @(negedge clk_i);
    check("R2 idle after sweep", 64'(outs()), 64'(bundle(1'b0, 16'h0, pulse_pol_i)));
  endtask

  task automatic measure(input string req, input logic [31:0] d, input logic [15:0] w,
                         input logic pol, input int retrig_k);
    int first, cnt, rises;
    logic prev;
    pulse_delay_i = d;
    pulse_width_i = w;
    pulse_pol_i   = pol;
    @(negedge clk_i);
    check("R10 idle level", 64'(pulse_o), 64'(pol));
    code_valid_i = 1'b1;
    code_i       = PCODE;
    first = -1; cnt = 0; rises = 0; prev = 1'b0;
    for (int k = 1; k <= 48; k++) begin
      @(negedge clk_i);
      if (pulse_o != pol) begin
        if (first < 0) first = k;
        cnt++;
        if (!prev) rises++;
      end
      prev = (pulse_o != pol);
      code_valid_i = (k == retrig_k);
    end
    code_valid_i = 1'b0;
    check({req, " first active"}, 64'(first), (w == 0) ? 64'(-1) : 64'(d + 2));
    check({req, " width"}, 64'(cnt), 64'(w));
    check({req, " pulse count"}, 64'(rises), (w == 0) ? 64'd0 : 64'd1);
  endtask

  initial begin
    // R1: reset state
    @(negedge clk_i);
    check("R1 reset outputs", 64'(outs()), 64'(bundle(1'b0, 16'h0, 1'b0)));
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", 64'(outs()), 64'(bundle(1'b0, 16'h0, 1'b0)));

    // R3: fill both tables, outputs untouched by writes
    for (int n = 0; n < 512; n++) begin
      wr_en_i   = 1'b1;
      wr_bank_i = n[8];
      wr_addr_i = n[7:0];
      wr_data_i = fill(n[8], n[7:0]);
      @(negedge clk_i);
      if (n[5:0] == 6'd0) check("R3 write quiet", 64'(outs()), 64'(bundle(1'b0, 16'h0, 1'b0)));
    end
    wr_en_i = 1'b0;

    // R1 live table 0 after reset, R2 full lookup sweep
    sweep(1'b0);
    bank_sel_i = 1'b1;
    @(negedge clk_i);
    sweep(1'b1);

    // R4: select change at same edge as code
    bank_sel_i   = 1'b0;
    code_valid_i = 1'b1;
    code_i       = 8'h05;
    @(negedge clk_i);
    check("R4 old table kept", 64'(act_o), 64'(fill(1'b1, 8'h05)));
    @(negedge clk_i);
    check("R4 new table live", 64'(act_o), 64'(fill(1'b0, 8'h05)));
    bank_sel_i = 1'b1;
    code_valid_i = 1'b0;
    @(negedge clk_i);

    // R5: write collision on live table
    wr_en_i = 1'b1; wr_bank_i = 1'b1; wr_addr_i = 8'h07; wr_data_i = 16'hBEEE;
    code_valid_i = 1'b1; code_i = 8'h07;
    @(negedge clk_i);
    check("R5 read before write", 64'(act_o), 64'(fill(1'b1, 8'h07)));
    // R3: write to the other table while looking up
    wr_bank_i = 1'b0; wr_data_i = 16'h1234;
    @(negedge clk_i);
    check("R5 new content", 64'(act_o), 64'h0000_BEEE);
    wr_en_i = 1'b0;
    @(negedge clk_i);
    check("R3 other table untouched", 64'(act_o), 64'h0000_BEEE);
    code_valid_i = 1'b0;

    // pulse entry in the live table: only bit 0
    wr_en_i = 1'b1; wr_bank_i = 1'b1; wr_addr_i = PCODE; wr_data_i = 16'h0001;
    @(negedge clk_i);
    wr_en_i = 1'b0;

    measure("R9 d0 w1", 32'd0, 16'd1, 1'b0, 0);
    measure("R9 d3 w4", 32'd3, 16'd4, 1'b0, 0);
    measure("R10 d1 w2 inverted", 32'd1, 16'd2, 1'b1, 0);
    measure("R9 R10 d20 w7", 32'd20, 16'd7, 1'b1, 0);
    measure("R11 zero width", 32'd4, 16'd0, 1'b0, 0);
    measure("R12 retrigger in delay", 32'd5, 16'd6, 1'b0, 3);
    measure("R12 retrigger while active", 32'd1, 16'd8, 1'b0, 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule